// File: doc/BRIEF.md
# Transmit Buffer Selection and Metadata Loader

This block decides which transmit buffer goes out next and fetches three words for it from a shared synchronous buffer memory: two metadata words and a timestamp word. Each buffer offers a priority value and a ready flag. Software and hardware can each withdraw a buffer at any moment through per-buffer abort masks, and neither source knows about the other. The fetched words and the buffer index are passed to the transmit engine with a one-cycle strobe. The engine then acknowledges before the next selection is loaded.

The memory address port is always driven by a flop, never by the selection logic. Registering the address costs one pipeline state. A load therefore spends four cycles in its load states (address set-up, first metadata, second metadata, timestamp). The address of each word is set two states before the state that captures its data. The selection is latched when a load starts and compared with the live selection in every load state. Any difference restarts the load from the first word of the new choice, or returns the loader to idle if nothing is eligible.

States: IDLE (waits for an eligible buffer; start goes to ADDR), ADDR (first word address on the memory port), META0 (captures the first metadata word), META1 (captures the second metadata word), STAMP (captures the timestamp and issues the strobe), HOLD (waits for the acknowledge and then goes to IDLE). In any of ADDR, META0, META1 or STAMP: if the selection still matches the latched one, the loader advances. If another buffer is now chosen, it restarts into ADDR. If no buffer is eligible, it drops to IDLE.

Top module: `txsel_loader`

## Requirements
- R1: A synchronous reset puts the loader in IDLE, sets `mem_addr` to zero, and clears `out_valid`, `out_idx` and the three data outputs.
- R2: A buffer is eligible when its ready bit is set and neither abort bit is set. The selected buffer is the eligible one with the largest priority value. Buffer i's priority sits in `buf_prio[i*PRIO_W +: PRIO_W]`. On equal priority the lowest index wins.
- R3: A set bit in `sw_abort` or `hw_abort` removes that buffer from selection in the same cycle. The two masks act independently and may change on any cycle.
- R4: `mem_addr` comes from a register. Its upper bits hold the buffer index and its lowest two bits the word offset: 0 for the first metadata word, 1 for the second, 2 for the timestamp. It changes only at an edge where a load starts, restarts or advances.
- R5: After the start cycle, `mem_addr` shows offset 0 during ADDR, offset 1 during META0, and offset 2 during META1 and STAMP. Each word is captured from `mem_rdata` one cycle after its address was shown.
- R6: With a stable selection, `out_valid` is high for exactly one cycle, five cycles after the IDLE cycle that started the load. In that cycle it is presented together with the latched index, both metadata words and the timestamp of that buffer.
- R7: If the selected index changes in any load state, the next cycle is ADDR with the new index and offset 0. If no buffer is eligible in a load state, the loader goes to IDLE and issues no strobe.
- R8: After a strobe no new load begins until `out_ack` is high. While waiting, `mem_addr` holds. `out_ack` outside HOLD has no effect.
- R9: The output registers hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| buf_ready | input | NUM_BUFS | Per-buffer ready flags |
| buf_prio | input | NUM_BUFS*PRIO_W | Per-buffer priority, buffer i at bits i*PRIO_W upward |
| sw_abort | input | NUM_BUFS | Software withdrawal mask |
| hw_abort | input | NUM_BUFS | Hardware withdrawal mask |
| mem_addr | output | IDX_W+2 | Registered word address to the buffer memory |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the address |
| out_ack | input | 1 | Consumer acknowledge of the last strobe |
| out_valid | output | 1 | One-cycle strobe: loaded words are ready |
| out_idx | output | IDX_W | Index of the loaded buffer |
| out_meta0 | output | DATA_W | First metadata word |
| out_meta1 | output | DATA_W | Second metadata word |
| out_stamp | output | DATA_W | Timestamp word |

## Verification
Each result has its own delay after a stimulus:
- A start, restart or advance shows on `mem_addr` one edge later.
- A word appears on `mem_rdata` one cycle after its address and is captured at the edge that ends that cycle.
- `out_valid` and the output words arrive five cycles after the IDLE start cycle.

The bench keeps a behavioural model that applies these delays. It compares address, strobe, index and words at every falling edge, after inputs have settled and before the next capture. Directed checks look at the restart address on the cycle after an abort is raised or cleared, and at the held address and strobe count over a wait without acknowledge.

// File: rtl/txsel_pkg.sv
package txsel_pkg;

    // Word offset inside one buffer's region of the memory.
    localparam int WORD_OFF_W = 2;
    localparam logic [WORD_OFF_W-1:0] OFF_META0 = 2'd0;
    localparam logic [WORD_OFF_W-1:0] OFF_META1 = 2'd1;
    localparam logic [WORD_OFF_W-1:0] OFF_STAMP = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_META0,
        ST_META1,
        ST_STAMP,
        ST_HOLD
    } ld_state_t;

endpackage

// File: rtl/txsel_prio_dec.sv
module txsel_prio_dec #(
    parameter int NUM_BUFS = 4,
    parameter int PRIO_W   = 3,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_BUFS-1:0]        buf_ready,
    input  logic [NUM_BUFS*PRIO_W-1:0] buf_prio,
    input  logic [NUM_BUFS-1:0]        sw_abort,
    input  logic [NUM_BUFS-1:0]        hw_abort,
    output logic                       sel_avail,
    output logic [IDX_W-1:0]           sel_idx
);

    logic [NUM_BUFS-1:0] elig;
    logic [PRIO_W-1:0]   prio_arr [NUM_BUFS];
    logic [PRIO_W-1:0]   best_prio;

    // Per-buffer eligibility and priority unpacking.
    for (genvar g = 0; g < NUM_BUFS; g++) begin : g_buf
        assign elig[g]     = buf_ready[g] & ~sw_abort[g] & ~hw_abort[g];
        assign prio_arr[g] = buf_prio[g*PRIO_W +: PRIO_W];
    end

    // Strictly-greater comparison keeps the lowest index on a tie.
    always_comb begin
        sel_avail = 1'b0;
        sel_idx   = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_BUFS; i++) begin
            if (elig[i] && (!sel_avail || (prio_arr[i] > best_prio))) begin
                sel_avail = 1'b1;
                sel_idx   = IDX_W'(i);
                best_prio = prio_arr[i];
            end
        end
    end

endmodule

// File: rtl/txsel_load_fsm.sv
module txsel_load_fsm
    import txsel_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_avail,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             out_ack,
    output ld_state_t        state_q,
    output logic [IDX_W-1:0] lat_idx_q,
    output logic             go_start,
    output logic             go_adv
);

    ld_state_t state_d;
    logic      loading;
    logic      match;

    // Transition decode.
    always_comb begin
        loading  = (state_q == ST_ADDR)  || (state_q == ST_META0) ||
                   (state_q == ST_META1) || (state_q == ST_STAMP);
        match    = sel_avail && (sel_idx == lat_idx_q);
        go_start = sel_avail && ((state_q == ST_IDLE) || (loading && !match));
        go_adv   = loading && match;

        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go_start) state_d = ST_ADDR;
            ST_ADDR:  state_d = go_adv ? ST_META0 : (go_start ? ST_ADDR : ST_IDLE);
            ST_META0: state_d = go_adv ? ST_META1 : (go_start ? ST_ADDR : ST_IDLE);
            ST_META1: state_d = go_adv ? ST_STAMP : (go_start ? ST_ADDR : ST_IDLE);
            ST_STAMP: state_d = go_adv ? ST_HOLD  : (go_start ? ST_ADDR : ST_IDLE);
            ST_HOLD:  if (out_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and latched selection.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            lat_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (go_start) lat_idx_q <= sel_idx;
        end
    end

endmodule

// File: rtl/txsel_word_regs.sv
module txsel_word_regs
    import txsel_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = IDX_W + WORD_OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ld_state_t         state_q,
    input  logic              go_start,
    input  logic              go_adv,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [IDX_W-1:0]  lat_idx,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_meta0,
    output logic [DATA_W-1:0] out_meta1,
    output logic [DATA_W-1:0] out_stamp
);

    logic [DATA_W-1:0] sh_meta0;
    logic [DATA_W-1:0] sh_meta1;

    // Address is always the address for the state after next.
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr  <= '0;
            sh_meta0  <= '0;
            sh_meta1  <= '0;
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_meta0 <= '0;
            out_meta1 <= '0;
            out_stamp <= '0;
        end else begin
            out_valid <= 1'b0;
            if (go_start) begin
                mem_addr <= {sel_idx, OFF_META0};
            end else if (go_adv) begin
                case (state_q)
                    ST_ADDR: begin
                        mem_addr <= {lat_idx, OFF_META1};
                    end
                    ST_META0: begin
                        mem_addr <= {lat_idx, OFF_STAMP};
                        sh_meta0 <= mem_rdata;
                    end
                    ST_META1: begin
                        sh_meta1 <= mem_rdata;
                    end
                    ST_STAMP: begin
                        out_valid <= 1'b1;
                        out_idx   <= lat_idx;
                        out_meta0 <= sh_meta0;
                        out_meta1 <= sh_meta1;
                        out_stamp <= mem_rdata;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/txsel_loader.sv
module txsel_loader
    import txsel_pkg::*;
#(
    parameter int NUM_BUFS = 4,
    parameter int PRIO_W   = 3,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = $clog2(NUM_BUFS),
    parameter int ADDR_W   = IDX_W + WORD_OFF_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_BUFS-1:0]        buf_ready,
    input  logic [NUM_BUFS*PRIO_W-1:0] buf_prio,
    input  logic [NUM_BUFS-1:0]        sw_abort,
    input  logic [NUM_BUFS-1:0]        hw_abort,
    output logic [ADDR_W-1:0]          mem_addr,
    input  logic [DATA_W-1:0]          mem_rdata,
    input  logic                       out_ack,
    output logic                       out_valid,
    output logic [IDX_W-1:0]           out_idx,
    output logic [DATA_W-1:0]          out_meta0,
    output logic [DATA_W-1:0]          out_meta1,
    output logic [DATA_W-1:0]          out_stamp
);

    logic             sel_avail;
    logic [IDX_W-1:0] sel_idx;
    logic [IDX_W-1:0] lat_idx;
    logic             go_start;
    logic             go_adv;
    ld_state_t        st_q;

    txsel_prio_dec #(
        .NUM_BUFS (NUM_BUFS),
        .PRIO_W   (PRIO_W),
        .IDX_W    (IDX_W)
    ) u_dec (
        .buf_ready (buf_ready),
        .buf_prio  (buf_prio),
        .sw_abort  (sw_abort),
        .hw_abort  (hw_abort),
        .sel_avail (sel_avail),
        .sel_idx   (sel_idx)
    );

    txsel_load_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sel_avail (sel_avail),
        .sel_idx   (sel_idx),
        .out_ack   (out_ack),
        .state_q   (st_q),
        .lat_idx_q (lat_idx),
        .go_start  (go_start),
        .go_adv    (go_adv)
    );

    txsel_word_regs #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .state_q   (st_q),
        .go_start  (go_start),
        .go_adv    (go_adv),
        .sel_idx   (sel_idx),
        .lat_idx   (lat_idx),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_meta0 (out_meta0),
        .out_meta1 (out_meta1),
        .out_stamp (out_stamp)
    );

endmodule

// File: rtl/txsel_loader_chk.sv
module txsel_loader_chk
    import txsel_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int ADDR_W = IDX_W + WORD_OFF_W
) (
    input logic              clk,
    input logic              rst,
    input logic              out_ack,
    input logic              out_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input ld_state_t         state_q,
    input logic              go_start,
    input logic              go_adv,
    input logic              sel_avail,
    input logic [IDX_W-1:0]  sel_idx,
    input logic [IDX_W-1:0]  lat_idx
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mem_addr == '0 && !out_valid && state_q == ST_IDLE));

    a_r4_addr_moves_on_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> $past(go_start || go_adv));

    a_r5_meta1_addr: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_META0) |->
        (mem_addr[WORD_OFF_W-1:0] == OFF_META1 && mem_addr[ADDR_W-1:WORD_OFF_W] == lat_idx));

    a_r5_stamp_addr: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_META1 || state_q == ST_STAMP) |->
        (mem_addr[WORD_OFF_W-1:0] == OFF_STAMP));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r6_after_stamp: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(state_q) == ST_STAMP && state_q == ST_HOLD));

    a_r7_restart_new_idx: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_ADDR || state_q == ST_META0 || state_q == ST_META1 ||
          state_q == ST_STAMP) && sel_avail && sel_idx != lat_idx) |=>
        (state_q == ST_ADDR && mem_addr[WORD_OFF_W-1:0] == OFF_META0 &&
         mem_addr[ADDR_W-1:WORD_OFF_W] == $past(sel_idx)));

    a_r7_drop_to_idle: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_ADDR || state_q == ST_META0 || state_q == ST_META1 ||
          state_q == ST_STAMP) && !sel_avail) |=> (state_q == ST_IDLE && !out_valid));

    a_r8_wait_for_ack: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !out_ack) |=> (state_q == ST_HOLD && $stable(mem_addr)));

endmodule

bind txsel_loader txsel_loader_chk #(
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_ack   (out_ack),
    .out_valid (out_valid),
    .mem_addr  (mem_addr),
    .state_q   (st_q),
    .go_start  (go_start),
    .go_adv    (go_adv),
    .sel_avail (sel_avail),
    .sel_idx   (sel_idx),
    .lat_idx   (lat_idx)
);

// File: tb/txsel_loader_tb_top.sv
`timescale 1ns/1ps
module txsel_loader_tb_top;

    localparam int NB = 4;
    localparam int PW = 3;
    localparam int DW = 32;
    localparam int IW = 2;
    localparam int AW = IW + 2;
    localparam int WPB = 4;   // words per buffer region

    logic          clk = 1'b0;
    logic          rst;
    logic [NB-1:0] buf_ready;
    logic [NB*PW-1:0] buf_prio;
    logic [NB-1:0] sw_abort;
    logic [NB-1:0] hw_abort;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic          out_ack;
    logic          out_valid;
    logic [IW-1:0] out_idx;
    logic [DW-1:0] out_meta0, out_meta1, out_stamp;

    always #5 clk = ~clk;

    txsel_loader #(.NUM_BUFS(NB), .PRIO_W(PW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .buf_ready(buf_ready), .buf_prio(buf_prio),
        .sw_abort(sw_abort), .hw_abort(hw_abort), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .out_ack(out_ack), .out_valid(out_valid),
        .out_idx(out_idx), .out_meta0(out_meta0), .out_meta1(out_meta1),
        .out_stamp(out_stamp)
    );

    function automatic logic [DW-1:0] memf(int a);
        return 32'h3C00_0000 ^ (32'(a) * 32'h0101_0111) ^ 32'h0000_A5A5;
    endfunction

    // Synchronous memory with one cycle of read latency.
    always @(posedge clk) mem_rdata <= memf(int'(mem_addr));

    int nchecks = 0;
    int nfail   = 0;
    int vcount  = 0;
    bit chk_on  = 0;
    bit seen_valid;
    int c_idx;
    logic [DW-1:0] c_ts;

    // Reference model state.
    int m_ph, m_lat, m_addr, m_idx;
    bit m_valid;
    logic [DW-1:0] m_rd, m_sh0, m_sh1, m_m0, m_m1, m_ts;
    int n_ph, n_lat, n_addr, n_idx;
    bit n_valid;
    logic [DW-1:0] n_rd, n_sh0, n_sh1, n_m0, n_m1, n_ts;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_next();
        bit found = 0;
        int best = 0;
        int bp = -1;
        for (int i = 0; i < NB; i++) begin
            if (buf_ready[i] && !sw_abort[i] && !hw_abort[i] &&
                int'(buf_prio[i*PW +: PW]) > bp) begin
                found = 1; best = i; bp = int'(buf_prio[i*PW +: PW]);
            end
        end
        n_ph = m_ph; n_lat = m_lat; n_addr = m_addr; n_idx = m_idx;
        n_sh0 = m_sh0; n_sh1 = m_sh1; n_m0 = m_m0; n_m1 = m_m1; n_ts = m_ts;
        n_valid = 0;
        n_rd = memf(m_addr);
        if (rst) begin
            n_ph = 0; n_lat = 0; n_addr = 0; n_idx = 0;
            n_sh0 = '0; n_sh1 = '0; n_m0 = '0; n_m1 = '0; n_ts = '0;
        end else if (m_ph == 0) begin
            if (found) begin n_ph = 1; n_lat = best; n_addr = best * WPB; end
        end else if (m_ph >= 1 && m_ph <= 4) begin
            if (found && best == m_lat) begin
                case (m_ph)
                    1: begin n_addr = m_lat * WPB + 1; n_ph = 2; end
                    2: begin n_sh0 = m_rd; n_addr = m_lat * WPB + 2; n_ph = 3; end
                    3: begin n_sh1 = m_rd; n_ph = 4; end
                    default: begin
                        n_m0 = m_sh0; n_m1 = m_sh1; n_ts = m_rd;
                        n_idx = m_lat; n_valid = 1; n_ph = 5;
                    end
                endcase
            end else if (found) begin
                n_ph = 1; n_lat = best; n_addr = best * WPB;
            end else begin
                n_ph = 0;
            end
        end else begin
            if (out_ack) n_ph = 0;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        seen_valid = out_valid;
        if (chk_on) begin
            chk(int'(mem_addr) == m_addr, "R5", "mem_addr", mem_addr, m_addr);
            chk(out_valid == m_valid, "R6", "out_valid", out_valid, m_valid);
            chk(int'(out_idx) == m_idx, "R2", "out_idx", out_idx, m_idx);
            chk(out_meta0 == m_m0, "R9", "out_meta0", out_meta0, m_m0);
            chk(out_meta1 == m_m1, "R9", "out_meta1", out_meta1, m_m1);
            chk(out_stamp == m_ts, "R9", "out_stamp", out_stamp, m_ts);
        end
        if (out_valid) begin
            vcount++; c_idx = int'(out_idx); c_ts = out_stamp;
        end
        model_next();
        @(posedge clk);
        #1;
        m_ph = n_ph; m_lat = n_lat; m_addr = n_addr; m_idx = n_idx; m_valid = n_valid;
        m_rd = n_rd; m_sh0 = n_sh0; m_sh1 = n_sh1; m_m0 = n_m0; m_m1 = n_m1; m_ts = n_ts;
    endtask

    task automatic wait_valid(string req);
        seen_valid = 0;
        for (int k = 0; k < 40 && !seen_valid; k++) tick();
        chk(seen_valid, req, "strobe seen", seen_valid, 1);
    endtask

    task automatic ack_and_stop();
        out_ack = 1; buf_ready = '0;
        tick();
        out_ack = 0;
        tick();
    endtask

    task automatic set_prio(int p0, int p1, int p2, int p3);
        buf_prio = {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        int v0;
        logic [AW-1:0] a0;
        rst = 1; buf_ready = '0; buf_prio = '0; sw_abort = '0; hw_abort = '0; out_ack = 0;
        m_ph = 0; m_lat = 0; m_addr = 0; m_idx = 0; m_valid = 0;
        m_rd = '0; m_sh0 = '0; m_sh1 = '0; m_m0 = '0; m_m1 = '0; m_ts = '0;
        repeat (3) tick();
        rst = 0; chk_on = 1;

        // R1: reset state
        chk(mem_addr == '0, "R1", "mem_addr after reset", mem_addr, 0);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(out_idx == '0, "R1", "out_idx after reset", out_idx, 0);
        chk(out_stamp == '0, "R1", "out_stamp after reset", out_stamp, 0);
        repeat (2) tick();

        // R2: tie between buffers 1 and 2 goes to the lower index
        set_prio(0, 5, 5, 0); buf_ready = 4'b0110;
        wait_valid("R6");
        chk(c_idx == 1, "R2", "tie index", c_idx, 1);
        chk(c_ts == memf(1 * WPB + 2), "R6", "stamp word", c_ts, memf(1 * WPB + 2));
        ack_and_stop();

        // R2: highest priority wins
        set_prio(1, 2, 7, 3); buf_ready = 4'b1111;
        wait_valid("R6");
        chk(c_idx == 2, "R2", "highest priority index", c_idx, 2);
        ack_and_stop();

        // R3: software abort, then both aborts
        sw_abort = 4'b0100; buf_ready = 4'b1111;
        wait_valid("R3");
        chk(c_idx == 3, "R3", "software abort skips buffer 2", c_idx, 3);
        ack_and_stop();
        hw_abort = 4'b1000; buf_ready = 4'b1111;
        wait_valid("R3");
        chk(c_idx == 1, "R3", "both aborts skip buffers 2 and 3", c_idx, 1);
        ack_and_stop();
        sw_abort = '0; hw_abort = '0;

        // R7: restart when the selection changes mid-load
        buf_ready = 4'b1111;
        tick();   // IDLE start
        tick();   // ADDR done, now META0
        sw_abort = 4'b0100;
        tick();
        chk(int'(mem_addr) == 3 * WPB, "R7", "restart address for buffer 3", mem_addr, 3 * WPB);
        chk(mem_addr[1:0] == 2'd0, "R4", "restart offset field", mem_addr[1:0], 0);
        sw_abort = '0;
        tick();
        chk(int'(mem_addr) == 2 * WPB, "R7", "restart back to buffer 2", mem_addr, 2 * WPB);
        wait_valid("R7");
        chk(c_idx == 2, "R7", "index after restarts", c_idx, 2);
        ack_and_stop();

        // R7: everything withdrawn mid-load drops to idle, no strobe
        buf_ready = 4'b1111;
        tick(); tick();
        buf_ready = '0;
        v0 = vcount;
        repeat (10) tick();
        chk(vcount == v0, "R7", "no strobe after drop", vcount, v0);

        // R8: no new load without acknowledge
        buf_ready = 4'b1111;
        wait_valid("R8");
        a0 = mem_addr; v0 = vcount;
        repeat (10) tick();
        chk(vcount == v0, "R8", "strobe count while waiting", vcount, v0);
        chk(mem_addr == a0, "R8", "address held while waiting", mem_addr, a0);
        chk(out_idx == 2'd2, "R9", "output index held", out_idx, 2);
        out_ack = 1;
        tick();
        out_ack = 0;
        wait_valid("R8");
        chk(c_idx == 2, "R8", "load after acknowledge", c_idx, 2);
        ack_and_stop();

        // R8: acknowledge while idle has no effect
        out_ack = 1;
        repeat (3) tick();
        out_ack = 0;
        set_prio(6, 1, 1, 1); buf_ready = 4'b1011;
        wait_valid("R8");
        chk(c_idx == 0, "R8", "load after idle acknowledge", c_idx, 0);
        ack_and_stop();
        repeat (3) tick();

        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule